// File: doc/BRIEF.md
# Prescaled JTAG Bit Shifter

This block clocks between one and eight bits of a single byte onto a JTAG port and captures TDO while it does so. A start pulse loads the byte, the bit count and the mode. The block then produces a TCK waveform. In each bit period TCK stays low for a setup interval and then goes high for a hold interval. Both intervals come from one prescaler parameter. Bits leave most significant first. In data mode they go out on TDI. In TMS mode they go out on TMS, and TDI is held at 0.

Each TDO sample is taken on the first clock edge at which TCK is high. The sample enters a single shift register from the bottom, and the outgoing bits leave from the top. When the last bit ends, TCK returns low and a one-cycle done pulse appears. At the same time the captured bits are presented right-aligned in the result byte. A surrounding command engine issues one start per bit group. That engine handles byte streaming and command decoding.

Top module: `jtag_bit_shifter`

## Requirements
- R1: Out of reset, tck_o, tdi_o, tms_o and done_o are 0 and result_o is 0x00.
- R2: In data mode (tms_mode_i = 0), bit k of a shift (k = 0 first) drives data_i[7-k] on tdi_o. Bits are taken from the top of the byte downward.
- R3: In TMS mode (tms_mode_i = 1), bit k drives data_i[7-k] on tms_o, and tdi_o stays 0 for the whole shift.
- R4: In data mode, tms_o follows the latched tms_level_i. When tms_last_i was 1 at start, tms_o is 1 during the final bit.
- R5: With prescaler P, each bit period is S = (P+1)/2 cycles with TCK low followed by H = P/2 cycles with TCK high, both divisions rounding down. Bit 0 begins in the cycle after the clock edge that accepts start.
- R6: tdi_o and tms_o change only while tck_o is low. They never change during a cycle in which tck_o is high.
- R7: The TDO sample of bit k is taken on the clock edge that ends the first TCK-high cycle of that bit. For N = nbits_m1_i + 1 bits, result_o[N-1-k] holds sample k, and result_o bits N and above are 0.
- R8: done_o is high for exactly one cycle, N*(S+H) cycles after the accepting edge. In that same cycle tck_o is low and result_o is valid.
- R9: A start pulse that arrives while a shift is in progress is ignored. The running shift's pins, timing and result are unchanged, and no further shift follows it.
- R10: The bit count is encoded as nbits_m1_i = N-1 on 3 bits, so 0 selects one bit and 7 selects eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a shift when idle |
| data_i | input | 8 | Byte whose upper bits are shifted out |
| nbits_m1_i | input | 3 | Number of bits minus one |
| tms_mode_i | input | 1 | 1: bits drive TMS; 0: bits drive TDI |
| tms_level_i | input | 1 | TMS level used during a data-mode shift |
| tms_last_i | input | 1 | Force TMS high on the final data-mode bit |
| tdo_i | input | 1 | Serial data from the target |
| tck_o | output | 1 | JTAG test clock |
| tdi_o | output | 1 | JTAG serial data to the target |
| tms_o | output | 1 | JTAG mode select |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | Captured TDO bits, right-aligned |

## Verification
Cycle c is counted from the edge that accepts start. The pin values for bit c/(S+H) appear in cycle c. TCK is high exactly when c mod (S+H) is at least S. done_o and result_o are due in cycle N*(S+H), and nothing is due after that.

The bench holds tdo_i constant across each bit period, so the sampling edge inside the period does not change the captured value. It compares every output at the falling clock edge of every cycle against a model built from these formulas. After each shift it checks several more idle cycles, which shows that an ignored start left no trace.

// File: rtl/jbs_pkg.sv
package jbs_pkg;

  // Cycles with TCK low before the rising edge.
  function automatic int setup_len(input int p);
    return (p + 1) / 2;
  endfunction

  // Cycles with TCK high after the rising edge.
  function automatic int hold_len(input int p);
    return p / 2;
  endfunction

  // Mask with the n lowest bits set.
  function automatic logic [31:0] low_ones(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Pin pair {tms, tdi} for one outgoing bit.
  function automatic logic [1:0] drive_pins(input logic bit_v, input logic tms_mode,
                                            input logic tms_lvl, input logic force_last,
                                            input logic is_last);
    logic [1:0] r;
    if (tms_mode) r = {bit_v, 1'b0};
    else          r = {(force_last && is_last) ? 1'b1 : tms_lvl, bit_v};
    return r;
  endfunction

endpackage

// File: rtl/jbs_phase_timer.sv
module jbs_phase_timer #(
  parameter int SETUP = 3,
  parameter int HOLD  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tck,
  output logic sample_ev,
  output logic bit_end
);
  localparam int PERIOD = SETUP + HOLD;
  localparam int CW     = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] S_C    = CW'(SETUP);
  localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_nx;

  assign cnt_nx    = (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
  assign sample_ev = run && (cnt_q == S_C);
  assign bit_end   = run && (cnt_q == LAST_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tck   <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      tck   <= 1'b0;
    end else if (run) begin
      cnt_q <= cnt_nx;
      tck   <= (cnt_nx >= S_C);
    end
  end

  // R5: the phase counter never passes the end of a bit period
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C);

  // R5: TCK rises only on the edge that leaves the last setup cycle
  p_tck_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> cnt_q == S_C);

endmodule

// File: rtl/jbs_shift_reg.sv
module jbs_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         din,
  output logic         msb,
  output logic [W-1:0] next_shifted
);
  logic [W-1:0] sr_q;

  assign msb          = sr_q[W-1];
  assign next_shifted = {sr_q[W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= load_val;
    else if (shift) sr_q <= next_shifted;
  end
endmodule

// File: rtl/jtag_bit_shifter.sv
module jtag_bit_shifter #(
  parameter int DATA_W   = 8,
  parameter int PRESCALE = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [DATA_W-1:0]           data_i,
  input  logic [$clog2(DATA_W)-1:0]   nbits_m1_i,
  input  logic                        tms_mode_i,
  input  logic                        tms_level_i,
  input  logic                        tms_last_i,
  input  logic                        tdo_i,
  output logic                        tck_o,
  output logic                        tdi_o,
  output logic                        tms_o,
  output logic                        done_o,
  output logic [DATA_W-1:0]           result_o
);
  import jbs_pkg::*;

  localparam int SETUP = setup_len(PRESCALE) < 1 ? 1 : setup_len(PRESCALE);
  localparam int HOLD  = hold_len(PRESCALE)  < 1 ? 1 : hold_len(PRESCALE);
  localparam int NW    = $clog2(DATA_W);
  localparam int BW    = NW + 1;

  logic          busy_q, mode_q, lvl_q, force_q, samp_q;
  logic [BW-1:0] left_q, nbits_q;
  logic          accept, sample_ev, bit_end, cap_bit, sr_msb, final_bit;
  logic [DATA_W-1:0] shifted;
  logic [1:0]    pins_first, pins_next;
  logic [BW-1:0] n_req;

  assign accept    = start_i && !busy_q;
  assign n_req     = BW'(nbits_m1_i) + 1'b1;
  assign cap_bit   = sample_ev ? tdo_i : samp_q;
  assign final_bit = bit_end && (left_q == BW'(1));

  assign pins_first = drive_pins(data_i[DATA_W-1], tms_mode_i, tms_level_i,
                                 tms_last_i, nbits_m1_i == '0);
  assign pins_next  = drive_pins(sr_msb, mode_q, lvl_q, force_q,
                                 left_q == BW'(2));

  jbs_phase_timer #(.SETUP(SETUP), .HOLD(HOLD)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (accept),
    .run       (busy_q),
    .tck       (tck_o),
    .sample_ev (sample_ev),
    .bit_end   (bit_end)
  );

  jbs_shift_reg #(.W(DATA_W)) u_sr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept),
    .load_val     ({data_i[DATA_W-2:0], 1'b0}),
    .shift        (bit_end),
    .din          (cap_bit),
    .msb          (sr_msb),
    .next_shifted (shifted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      mode_q   <= 1'b0;
      lvl_q    <= 1'b0;
      force_q  <= 1'b0;
      samp_q   <= 1'b0;
      left_q   <= '0;
      nbits_q  <= '0;
      tdi_o    <= 1'b0;
      tms_o    <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (sample_ev) samp_q <= tdo_i;
      if (accept) begin
        busy_q  <= 1'b1;
        mode_q  <= tms_mode_i;
        lvl_q   <= tms_level_i;
        force_q <= tms_last_i;
        left_q  <= n_req;
        nbits_q <= n_req;
        {tms_o, tdi_o} <= pins_first;
      end else if (final_bit) begin
        busy_q   <= 1'b0;
        done_o   <= 1'b1;
        result_o <= shifted & DATA_W'(low_ones(int'(nbits_q)));
      end else if (bit_end) begin
        left_q <= left_q - 1'b1;
        {tms_o, tdi_o} <= pins_next;
      end
    end
  end

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: TCK is back low when done is reported
  p_done_tck_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !tck_o);

  // R6: data pins are frozen while TCK is high
  p_pins_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tck_o |-> ($stable(tdi_o) && $stable(tms_o)));

  // R3: TDI is parked at 0 throughout a TMS-mode shift
  p_tms_mode_tdi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mode_q) |-> !tdi_o);

  // R9: a start during a shift does not reload the latched mode or count
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> ($stable(mode_q) && $stable(nbits_q)));

endmodule

// File: tb/jtag_bit_shifter_bench.sv
module jtag_bit_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 5;
  localparam int S  = (P + 1) / 2;
  localparam int H  = P / 2;
  localparam int T  = S + H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [2:0] nbits_m1_i = '0;
  logic       tms_mode_i = 1'b0, tms_level_i = 1'b0, tms_last_i = 1'b0, tdo_i = 1'b0;
  logic       tck_o, tdi_o, tms_o, done_o;
  logic [7:0] result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  jtag_bit_shifter #(.DATA_W(8), .PRESCALE(P)) u_jtag_bit_shifter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .nbits_m1_i(nbits_m1_i), .tms_mode_i(tms_mode_i), .tms_level_i(tms_level_i),
    .tms_last_i(tms_last_i), .tdo_i(tdo_i), .tck_o(tck_o), .tdi_o(tdi_o),
    .tms_o(tms_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One shift, compared cycle by cycle against the requirement formulas.
  task automatic run_shift(input logic [7:0] data, input int n, input logic mode,
                           input logic lvl, input logic frc, input logic [7:0] pat,
                           input bit inject);
    int k;
    int exp_tdi, exp_tms, exp_tck, exp_done;
    @(negedge clk);
    data_i = data; nbits_m1_i = 3'(n - 1); tms_mode_i = mode;
    tms_level_i = lvl; tms_last_i = frc; start_i = 1'b1;
    tdo_i = pat[n-1];
    @(posedge clk);
    for (int c = 0; c <= n * T + T + 2; c++) begin
      @(negedge clk);
      start_i = 1'b0;
      // R9: a start with different settings arrives mid-shift
      if (inject && c == 2) begin
        start_i = 1'b1; data_i = ~data; tms_mode_i = ~mode; nbits_m1_i = 3'd7;
      end
      k = (c / T < n) ? c / T : n - 1;
      if (c / T < n) tdo_i = pat[n-1-(c/T)];
      exp_tck  = (c < n * T && (c % T) >= S) ? 1 : 0;
      exp_done = (c == n * T) ? 1 : 0;
      if (c <= n * T) begin
        if (mode) begin
          exp_tdi = 0;
          exp_tms = int'(data[7-k]);
        end else begin
          exp_tdi = int'(data[7-k]);
          exp_tms = (frc && k == n - 1) ? 1 : int'(lvl);
        end
        chk(mode ? "R3 tdi parked" : "R2 tdi bit", int'(tdi_o), exp_tdi);
        chk(mode ? "R3 tms bit" : "R4 tms level", int'(tms_o), exp_tms);
      end
      chk(inject ? "R9 R5 tck" : "R5 tck", int'(tck_o), exp_tck);
      chk(inject ? "R9 R8 done" : "R8 done", int'(done_o), exp_done);
      if (c == n * T)
        chk("R7 R10 result", int'(result_o), int'(pat & 8'((1 << n) - 1)));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 tck", int'(tck_o), 0);
    chk("R1 tdi", int'(tdi_o), 0);
    chk("R1 tms", int'(tms_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 result", int'(result_o), 0);
    rst_n = 1'b1;
    // R2 R7: eight data bits
    run_shift(8'hA5, 8, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0);
    // R3: TMS mode, five bits
    run_shift(8'hB3, 5, 1'b1, 1'b0, 1'b0, 8'h15, 1'b0);
    // R4 R10: single bit with TMS forced on the last bit
    run_shift(8'h80, 1, 1'b0, 1'b0, 1'b1, 8'h01, 1'b0);
    // R4: three bits, force on last with level low
    run_shift(8'h6F, 3, 1'b0, 1'b0, 1'b1, 8'h02, 1'b0);
    // R9: start arrives while busy
    run_shift(8'h4D, 3, 1'b0, 1'b1, 1'b0, 8'h05, 1'b1);
    // R7: all-ones capture over seven bits, TMS mode
    run_shift(8'h01, 7, 1'b1, 1'b1, 1'b1, 8'h7F, 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule